// File: doc/BRIEF.md
# Streaming Softmax-Weighted Value Accumulator

This block produces the attention result for one query without storing a score row. A stream of keys arrives, one per cycle. Each key carries a scalar score and a value vector of `LANES` signed lanes. The block keeps three things across the sequence: the largest score seen so far, a running softmax denominator, and a running weighted sum for each lane. When a new score raises the maximum, the older state is scaled down by the matching factor. The new value is weighted against the current maximum. Each of these weightings is a fused exponential-times-value step, so every accepted key uses two of them.

Scores are taken in base-2 logarithmic units: an upstream stage has already multiplied them by log2(e). The exponential of a non-positive integer difference `-k` is therefore the factor 2^-k. This factor is applied as an arithmetic right shift of a fixed-point quantity that carries `FRAC` = 15 fraction bits. When the difference exceeds 15, the contribution is treated as underflow and becomes exactly zero.

An input flag marks the last key of a sequence. One normalising division per lane follows, done by a bit-serial divider. While that divider runs, the input side is stalled. The normalised vector is then offered on a valid/ready output. After that output has been taken, the next key starts a fresh sequence.

Top module: `oa_attn_acc`

## Requirements
- R1: Immediately after reset `in_ready` is 1 and `out_valid` is 0.
- R2: The first key of a sequence ignores all earlier state. The maximum becomes its score, the denominator becomes 1.0 (2^15), and each lane accumulator becomes `v << 15`. A one-key sequence therefore returns each lane as `v * 256`.
- R3: For every later key with score `s`, the new maximum is `M' = max(M, s)`, with `a = M' - M` and `b = M' - s`. The denominator becomes `w(D, a) + w(2^15, b)`. Each lane becomes `w(O, a) + w(v << 15, b)`. Here `w(x, k)` is `x` arithmetically shifted right by `k`, rounding toward minus infinity.
- R4: When the shift amount `k` is greater than 15, `w(x, k)` is exactly 0. A key whose score lies more than 15 below the maximum contributes nothing, and a jump of more than 15 in the maximum discards all earlier state.
- R5: While a sequence is being accumulated, `in_ready` stays 1, so one key is accepted on every clock cycle.
- R6: Once the key with `in_last` = 1 has been accepted, `in_ready` stays 0 until the output handshake completes. Keys offered during that interval are not accepted and do not change the result.
- R7: Output lane `j` equals `(O_j * 2^8) / D`, truncated toward zero and taken as a 17-bit two's-complement value.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_vals` does not change.
- R9: After an output handshake, the next accepted key is treated as the first key of a new sequence (R2), whatever scores came before.
- R10: Lane `j` of the input occupies `in_vals[j*8 +: 8]`. Lane `j` of the output occupies `out_vals[j*17 +: 17]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A key is offered |
| in_ready | output | 1 | The key is accepted on this edge if `in_valid` is 1 |
| in_score | input | 8 | Signed score in log2 units |
| in_vals | input | 32 | Four signed 8-bit value lanes |
| in_last | input | 1 | Marks the final key of the sequence |
| out_valid | output | 1 | The normalised vector is available |
| out_ready | input | 1 | The consumer takes the vector |
| out_vals | output | 68 | Four signed 17-bit lanes, each with 8 fraction bits |

## Verification
The scoreboard covers these cases:

- **Rising scores.** A design that forgot to rescale would overweight earlier keys when the maximum rises.
- **Falling scores.** A design that swapped the old and new shift amounts would return wrong weighted sums when scores fall.
- **Gaps over 15 in both directions.** A design that let the shift wrap or saturate would leak stale or underflowed terms.
- **Odd negative averages.** A design that rounded by flooring instead of truncating would return a quotient one LSB away from the expected value.
- **High-score sequence followed by a low-score one.** A design that failed to reinitialise after a handshake would carry the old maximum forward and zero the new sequence.
- **Inputs offered during the divide.** Keys presented while the divider runs would corrupt the next result if they were accepted.
- **Held `out_ready`.** A design that dropped `out_valid` or let the data change while `out_ready` was low would be caught here.

// File: rtl/oa_pkg.sv
// Shared types for the streaming attention accumulator.
package oa_pkg;
    // Block phase: accumulating keys, loading the divider, dividing, presenting output
    typedef enum logic [1:0] {
        PH_ACC  = 2'd0,
        PH_LOAD = 2'd1,
        PH_RUN  = 2'd2,
        PH_OUT  = 2'd3
    } phase_t;
endpackage

// File: rtl/oa_expmul.sv
// Fused exponential-times-value step in the base-2 domain: multiplies val by
// 2^-sh as an arithmetic right shift (rounds toward minus infinity).
// Assumes sh is a non-negative difference of scores; any shift above MAXSH is
// treated as underflow and yields exactly zero.
module oa_expmul #(
    parameter int W     = 40,
    parameter int SHW   = 9,
    parameter int MAXSH = 15
) (
    input  logic signed [W-1:0]   val,
    input  logic        [SHW-1:0] sh,
    output logic signed [W-1:0]   res
);
    // Clip-to-zero or shift
    always_comb begin
        if (sh > SHW'(MAXSH)) res = '0;
        else                  res = val >>> sh;
    end
endmodule

// File: rtl/oa_state.sv
// Running state of the online softmax: maximum score, denominator and per-lane
// weighted sums. One key is folded in per accepted cycle using two fused
// exponential-multiply paths per quantity (rescale old, weight new).
// Assumes acc and restart are never asserted in the same cycle.
module oa_state #(
    parameter int LANES = 4,
    parameter int SW    = 8,
    parameter int VW    = 8,
    parameter int FRAC  = 15,
    parameter int MAXSH = 15,
    parameter int LW    = 32,
    parameter int AW    = 40
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    acc,
    input  logic                    restart,
    input  logic signed [SW-1:0]    score,
    input  logic [LANES*VW-1:0]     vals,
    output logic [LW-1:0]           den_o,
    output logic [LANES*AW-1:0]     num_o
);
    localparam int SHW = SW + 1;
    localparam logic signed [LW-1:0] ONE = LW'(1) << FRAC;

    logic                  first_q;
    logic signed [SW-1:0]  max_q;
    logic signed [SW-1:0]  max_n;
    logic [LW-1:0]         den_q;
    logic [LW-1:0]         den_n;
    logic [SHW-1:0]        d_old;
    logic [SHW-1:0]        d_new;
    logic signed [LW-1:0]  den_old_in;
    logic signed [LW-1:0]  den_old_r;
    logic signed [LW-1:0]  den_new_r;
    logic [LANES*AW-1:0]   num_q;
    logic [LANES*AW-1:0]   num_n;

    // New maximum; the first key of a sequence takes its own score
    always_comb begin
        if (first_q || (score > max_q)) max_n = score;
        else                            max_n = max_q;
    end

    // Non-negative shift amounts for the old state and for the new key
    always_comb begin
        d_old = {max_n[SW-1], max_n} - {max_q[SW-1], max_q};
        d_new = {max_n[SW-1], max_n} - {score[SW-1], score};
    end

    // Old denominator is forced to zero on the first key (maximum of minus infinity)
    always_comb den_old_in = first_q ? '0 : $signed(den_q);

    oa_expmul #(.W(LW), .SHW(SHW), .MAXSH(MAXSH)) u_den_old (
        .val(den_old_in), .sh(d_old), .res(den_old_r));
    oa_expmul #(.W(LW), .SHW(SHW), .MAXSH(MAXSH)) u_den_new (
        .val(ONE), .sh(d_new), .res(den_new_r));

    // Sum of rescaled old denominator and new weight
    always_comb den_n = den_old_r + den_new_r;

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic signed [AW-1:0] old_in;
        logic signed [AW-1:0] old_r;
        logic signed [AW-1:0] vx;
        logic signed [AW-1:0] new_r;

        // Gate old lane state on first key; align value to the fixed-point scale
        always_comb begin
            old_in = first_q ? '0 : $signed(num_q[j*AW +: AW]);
            vx     = {{(AW-VW-FRAC){vals[j*VW+VW-1]}}, vals[j*VW +: VW], {FRAC{1'b0}}};
        end

        oa_expmul #(.W(AW), .SHW(SHW), .MAXSH(MAXSH)) u_old (
            .val(old_in), .sh(d_old), .res(old_r));
        oa_expmul #(.W(AW), .SHW(SHW), .MAXSH(MAXSH)) u_new (
            .val(vx), .sh(d_new), .res(new_r));

        // Lane sum of rescaled history and weighted new value
        always_comb num_n[j*AW +: AW] = old_r + new_r;
    end

    // State registers: fold in an accepted key, or arm reinitialisation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q <= 1'b1;
            max_q   <= '0;
            den_q   <= '0;
            num_q   <= '0;
        end else if (acc) begin
            first_q <= 1'b0;
            max_q   <= max_n;
            den_q   <= den_n;
            num_q   <= num_n;
        end else if (restart) begin
            first_q <= 1'b1;
        end
    end

    assign den_o = den_q;
    assign num_o = num_q;

    // R3
    max_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !first_q) |=> (max_q >= $past(max_q)));
    // R3
    den_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (den_q != '0));
    // R2
    first_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && first_q) |=> (max_q == $past(score) && den_q == LW'(ONE)));
endmodule

// File: rtl/oa_divider.sv
// Bit-serial restoring divider, all lanes in parallel sharing one step counter.
// Each lane computes (num * 2^OF) / den truncated toward zero.
// Assumes den is non-zero and the quotient magnitude fits in OW-1 bits.
module oa_divider #(
    parameter int LANES = 4,
    parameter int AW    = 40,
    parameter int LW    = 32,
    parameter int OF    = 8,
    parameter int OW    = 17
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [LANES*AW-1:0]   num,
    input  logic [LW-1:0]         den,
    output logic                  done,
    output logic [LANES*OW-1:0]   quot
);
    localparam int NB = AW + OF;
    localparam int CW = $clog2(NB + 1);

    logic          run_q;
    logic [CW-1:0] cnt_q;

    // Step counter: NB iterations per division, done pulses with the final quotient
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
            done  <= 1'b0;
        end else begin
            done <= run_q && (cnt_q == CW'(1));
            if (start) begin
                run_q <= 1'b1;
                cnt_q <= CW'(NB);
            end else if (run_q) begin
                cnt_q <= cnt_q - CW'(1);
                if (cnt_q == CW'(1)) run_q <= 1'b0;
            end
        end
    end

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [NB-1:0]        sh_q;
        logic [LW-1:0]        rem_q;
        logic [OW-1:0]        q_q;
        logic                 neg_q;
        logic signed [AW-1:0] n_s;
        logic [AW-1:0]        mag;
        logic [LW:0]          trial;

        // Operand magnitude and next partial remainder
        always_comb begin
            n_s   = $signed(num[j*AW +: AW]);
            mag   = n_s[AW-1] ? AW'(-n_s) : AW'(n_s);
            trial = {rem_q, sh_q[NB-1]};
        end

        // One restoring step per cycle
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sh_q  <= '0;
                rem_q <= '0;
                q_q   <= '0;
                neg_q <= 1'b0;
            end else if (start) begin
                sh_q  <= {mag, {OF{1'b0}}};
                rem_q <= '0;
                q_q   <= '0;
                neg_q <= n_s[AW-1];
            end else if (run_q) begin
                sh_q <= sh_q << 1;
                if (trial >= {1'b0, den}) begin
                    rem_q <= LW'(trial - {1'b0, den});
                    q_q   <= {q_q[OW-2:0], 1'b1};
                end else begin
                    rem_q <= trial[LW-1:0];
                    q_q   <= {q_q[OW-2:0], 1'b0};
                end
            end
        end

        // Restore sign: truncation toward zero
        always_comb quot[j*OW +: OW] = neg_q ? (~q_q + OW'(1)) : q_q;
    end

    // R7
    div_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (den != '0));
endmodule

// File: rtl/oa_attn_acc.sv
// Streaming single-query attention accumulator. Accepts one key per cycle,
// keeps online softmax state, and on the last key divides once per lane and
// presents the normalised vector on a valid/ready output.
// Assumes at most 2^16 keys per sequence so the denominator cannot overflow.
module oa_attn_acc #(
    parameter int LANES = 4,
    parameter int SW    = 8,
    parameter int VW    = 8,
    parameter int FRAC  = 15,
    parameter int MAXSH = 15,
    parameter int LW    = 32,
    parameter int AW    = 40,
    parameter int OF    = 8,
    parameter int OW    = VW + OF + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [SW-1:0]         in_score,
    input  logic [LANES*VW-1:0]   in_vals,
    input  logic                  in_last,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [LANES*OW-1:0]   out_vals
);
    import oa_pkg::*;

    phase_t              phase_q;
    logic                acc;
    logic                restart;
    logic                div_done;
    logic [LW-1:0]       den;
    logic [LANES*AW-1:0] num;

    // Handshake decode from phase
    always_comb begin
        in_ready  = (phase_q == PH_ACC);
        out_valid = (phase_q == PH_OUT);
        acc       = in_ready && in_valid;
        restart   = out_valid && out_ready;
    end

    // Phase sequencing: accumulate, load divider, divide, present
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_ACC;
        else begin
            case (phase_q)
                PH_ACC:  if (acc && in_last) phase_q <= PH_LOAD;
                PH_LOAD: phase_q <= PH_RUN;
                PH_RUN:  if (div_done) phase_q <= PH_OUT;
                PH_OUT:  if (out_ready) phase_q <= PH_ACC;
                default: phase_q <= PH_ACC;
            endcase
        end
    end

    oa_state #(
        .LANES(LANES), .SW(SW), .VW(VW), .FRAC(FRAC),
        .MAXSH(MAXSH), .LW(LW), .AW(AW)
    ) u_state (
        .clk(clk), .rst_n(rst_n), .acc(acc), .restart(restart),
        .score($signed(in_score)), .vals(in_vals),
        .den_o(den), .num_o(num)
    );

    oa_divider #(
        .LANES(LANES), .AW(AW), .LW(LW), .OF(OF), .OW(OW)
    ) u_div (
        .clk(clk), .rst_n(rst_n), .start(phase_q == PH_LOAD),
        .num(num), .den(den), .done(div_done), .quot(out_vals)
    );

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_vals)));
    // R6
    no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && in_last) |=> !in_ready);
    // R7
    out_after_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(div_done));
    // R9
    restart_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> in_ready);
endmodule

// File: tb/tb_oa_attn_acc.sv
`timescale 1ns/1ps
module tb_oa_attn_acc;
    localparam int LANES = 4;
    localparam int SW = 8;
    localparam int VW = 8;
    localparam int OW = 17;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [SW-1:0] in_score = '0;
    logic [LANES*VW-1:0] in_vals = '0;
    logic in_last = 1'b0;
    logic out_valid;
    logic out_ready = 1'b1;
    logic [LANES*OW-1:0] out_vals;

    int n_chk = 0;
    int n_bad = 0;
    logic [LANES*OW-1:0] exp_q[$];
    int sc_a[16];
    int v_a[16][LANES];

    always #10 clk = ~clk;

    oa_attn_acc dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_score(in_score), .in_vals(in_vals), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_vals(out_vals));

    // Base-2 weight: arithmetic shift, zero beyond 15 (R3, R4)
    function automatic longint wt(longint x, int k);
        if (k > 15) return 0;
        return x >>> k;
    endfunction

    // Reference model of one sequence per the requirements
    function automatic logic [LANES*OW-1:0] model(int n);
        longint m, l, o[LANES];
        logic [LANES*OW-1:0] r;
        m = sc_a[0];
        l = 32768;
        for (int j = 0; j < LANES; j++) o[j] = longint'(v_a[0][j]) * 32768;
        for (int i = 1; i < n; i++) begin
            longint mn;
            mn = (sc_a[i] > m) ? sc_a[i] : m;
            l = wt(l, int'(mn - m)) + wt(32768, int'(mn - sc_a[i]));
            for (int j = 0; j < LANES; j++)
                o[j] = wt(o[j], int'(mn - m)) + wt(longint'(v_a[i][j]) * 32768, int'(mn - sc_a[i]));
            m = mn;
        end
        for (int j = 0; j < LANES; j++) r[j*OW +: OW] = OW'((o[j] * 256) / l);
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Driver: push expectation, stream keys back to back, then poke the busy input
    task automatic send_seq(input int n);
        exp_q.push_back(model(n));
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b1;
            in_score = SW'(sc_a[i]);
            for (int j = 0; j < LANES; j++) in_vals[j*VW +: VW] = VW'(v_a[i][j]);
            in_last = (i == n - 1);
            @(negedge clk);
            check(in_ready == 1'b1, "R5 in_ready during accumulation", in_ready, 1);
            @(posedge clk); #1;
        end
        // R6: garbage offered while dividing must not be accepted
        for (int g = 0; g < 6; g++) begin
            in_valid = 1'b1;
            in_last  = 1'b1;
            in_score = SW'($urandom_range(0, 255));
            in_vals  = LANES*VW'({$urandom, $urandom});
            @(negedge clk);
            check(in_ready == 1'b0, "R6 in_ready while busy", in_ready, 0);
            @(posedge clk); #1;
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic drain();
        wait (exp_q.size() == 0);
        @(posedge clk); #1;
    endtask

    // Monitor / scoreboard with output hold check
    logic hold_pend = 1'b0;
    logic [LANES*OW-1:0] held;
    always @(negedge clk) begin
        if (rst_n) begin
            if (hold_pend)
                check(out_valid && out_vals == held, "R8 output held under backpressure", longint'(out_vals[31:0]), longint'(held[31:0]));
            hold_pend = out_valid && !out_ready;
            held = out_vals;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) check(1'b0, "R7 unexpected output", 1, 0);
                else begin
                    logic [LANES*OW-1:0] e;
                    e = exp_q.pop_front();
                    n_chk++;
                    if (out_vals !== e) begin
                        n_bad++;
                        $display("FAIL R7 result actual=%h expected=%h", out_vals, e);
                    end
                end
            end
        end
    end

    task automatic set_lanes(input int i, input int a, input int b, input int c, input int d);
        v_a[i][0] = a; v_a[i][1] = b; v_a[i][2] = c; v_a[i][3] = d;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
        check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
        @(posedge clk); #1;

        // R2, R10: single key returns v*256 per lane
        sc_a[0] = 5; set_lanes(0, 10, -3, 0, 127);
        send_seq(1); drain();

        // R3: equal scores average
        sc_a[0] = 0; set_lanes(0, 10, 20, -7, 100);
        sc_a[1] = 0; set_lanes(1, 30, -20, 4, -100);
        send_seq(2); drain();

        // R3: rising scores rescale the old state
        for (int i = 0; i < 4; i++) begin
            sc_a[i] = i;
            set_lanes(i, 10 * i - 15, 64, -128, i + 1);
        end
        send_seq(4); drain();

        // R3: falling scores weight new keys down
        for (int i = 0; i < 4; i++) begin
            sc_a[i] = 3 - 2 * i;
            set_lanes(i, 50 - 20 * i, -9, 127, 3 * i);
        end
        send_seq(4); drain();

        // R4: jump of 20 discards history
        sc_a[0] = 0;  set_lanes(0, 100, 100, 100, 100);
        sc_a[1] = 20; set_lanes(1, -5, 7, 0, 33);
        send_seq(2); drain();

        // R4: key 16 below the maximum contributes nothing
        sc_a[0] = 10;  set_lanes(0, 40, -40, 1, 2);
        sc_a[1] = -6;  set_lanes(1, -128, 127, 127, -128);
        send_seq(2); drain();

        // R7: odd negative averages truncate toward zero
        sc_a[0] = 0; set_lanes(0, -1, -3, -5, 1);
        sc_a[1] = 0; set_lanes(1, 0, 0, 0, -2);
        sc_a[2] = 0; set_lanes(2, 0, -1, 0, 0);
        send_seq(3); drain();

        // R9: high-score sequence then a low-score one
        sc_a[0] = 120; set_lanes(0, 1, 2, 3, 4);
        sc_a[1] = 127; set_lanes(1, 5, 6, 7, 8);
        send_seq(2); drain();
        sc_a[0] = -100; set_lanes(0, -60, 60, -1, 9);
        send_seq(1); drain();

        // R8: backpressure on the output
        out_ready = 1'b0;
        sc_a[0] = 2; set_lanes(0, 11, 22, 33, 44);
        sc_a[1] = 3; set_lanes(1, -11, -22, -33, -44);
        send_seq(2);
        wait (out_valid);
        repeat (5) @(posedge clk);
        #1 out_ready = 1'b1;
        drain();

        // Random sequences across R3, R4, R7
        for (int t = 0; t < 12; t++) begin
            int n;
            n = $urandom_range(1, 12);
            for (int i = 0; i < n; i++) begin
                sc_a[i] = $urandom_range(0, 40) - 20;
                for (int j = 0; j < LANES; j++) v_a[i][j] = $urandom_range(0, 255) - 128;
            end
            send_seq(n); drain();
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule